// File: doc/BRIEF.md
# Paged Bus Mapper with Write Shadowing

The block sits between a processor with a 24-bit address bus and its physical storage. Every processor access is translated through a page map that holds one entry per 256-byte page. Each entry names a destination bank and carries three access flags. A second table holds one storage descriptor per destination bank. A descriptor can make a bank readable, writable, both or neither. It can also send reads to ROM while writes go to RAM, and it gives the physical 64 KB base used for each direction.

IO-flagged pages are forwarded to a separate IO port and never touch storage. A write to a shadowed page is performed twice: once in the destination bank, and then again in bank (destination + 0xE0) at the same 16-bit offset. Each access is charged either a fast or a slow cost in clock units. The processor is held until that cost has elapsed. Two phase counters track the running position against the fast and slow bus periods.

The installed RAM size is selected by `mem_model_i`. A bank base beyond the installed size behaves as absent storage.

Top module: `bus_mapper`

## Requirements
- R1: The map entry is selected by `cpu_addr_i[8+MAP_IDX_W-1:8]`. An entry holds the destination bank in bits [15:8] and flags in bits [7:0]. A descriptor holds read-enable [18], write-enable [17], read-from-ROM [16], read base [15:8] and write base [7:0]. The physical address is {base, cpu_addr_i[15:0]}.
- R2: After reset, every map entry is destination 0 with no flags, and every descriptor is all zero. Both phase counters are 0, `cost_o` is 0 and `cpu_ready_o` is low. As a result, any access then reads 0xFF and writes nothing.
- R3: For a read with read-enable set, the byte is fetched from ROM at {read base, offset} when read-from-ROM is 1, and from RAM at that address otherwise. The byte is returned on `cpu_rdata_o` while `cpu_ready_o` is high, and exactly one storage strobe is issued.
- R4: A read from a bank without read-enable, or from a RAM read base outside the installed size, returns 0xFF and issues no storage strobe.
- R5: A write performs one RAM write at {write base, offset} when write-enable is set and the write base is installed. Otherwise the write is discarded.
- R6: When flag bit 2 (IO) is set, one IO strobe carries the full 24-bit address and the write data. No RAM or ROM strobe is issued, and read data is taken from `io_rdata_i`.
- R7: A write to a page with flag bit 0 (shadow) and no IO flag is followed by a second RAM write. The second write goes at the same offset, using the write base of the descriptor of bank (destination + 0xE0) mod 256. It happens only if the primary write happened, and only if that descriptor is write-enabled and its write base is installed.
- R8: The cost is 14 when flag bit 1 (slow) is set, or when the access is a write with flag bit 0 set. Otherwise the cost is 5. The cost is shown on `cost_o`.
- R9: A request is accepted on an edge where `cpu_req_i` is high and no access is in progress. `cpu_ready_o` is then high for exactly one cycle: the cost-th cycle after the accepting edge.
- R10: When an access completes, the fast phase becomes (fast + cost) mod 5 and the slow phase becomes (slow + cost) mod 14. Both phases are otherwise unchanged.
- R11: `mem_model_i` selects the installed RAM size in 64 KB banks: 0 selects 4 banks, 1 selects 20, and 2 or 3 select 132. Bases at or above the limit are absent.
- R12: A map or descriptor write takes effect for requests accepted after its edge. A request accepted on the same edge uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_model_i | input | 2 | Installed RAM size select |
| cpu_req_i | input | 1 | Access request |
| cpu_we_i | input | 1 | 1 = write |
| cpu_addr_i | input | 24 | Processor address |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data, valid with ready |
| cpu_ready_o | output | 1 | Access complete pulse |
| cost_o | output | 4 | Cost of current or last access |
| fast_phase_o | output | 3 | Fast bus phase |
| slow_phase_o | output | 4 | Slow bus phase |
| map_we_i | input | 1 | Map entry write strobe |
| map_idx_i | input | MAP_IDX_W | Map entry index |
| map_wdata_i | input | 16 | Map entry value |
| desc_we_i | input | 1 | Descriptor write strobe |
| desc_idx_i | input | 8 | Descriptor bank index |
| desc_wdata_i | input | 19 | Descriptor value |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 24 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after strobe |
| rom_re_o | output | 1 | ROM read strobe |
| rom_addr_o | output | 24 | ROM address |
| rom_rdata_i | input | 8 | ROM read data, one cycle after strobe |
| io_req_o | output | 1 | IO access strobe |
| io_we_o | output | 1 | IO write |
| io_addr_o | output | 24 | IO address |
| io_wdata_o | output | 8 | IO write data |
| io_rdata_i | input | 8 | IO read data, same cycle as strobe |

## Verification
Two things can land on the same clock edge: a configuration write to the page map, and the acceptance of a processor request that targets the very entry being rewritten. The bench drives both together on one edge. It predicts the result from its copy of the map taken before the write, and expects the old entry's behaviour for that access. It then issues a second access to the same page and expects the new entry. Randomized traffic mixes further such collisions with accesses through random descriptors and installed-size changes.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int ADDR_W = 24;
  localparam int OFS_W  = 16;
  localparam int BANK_W = ADDR_W - OFS_W;

  localparam int FLG_SHADOW = 0;
  localparam int FLG_SLOW   = 1;
  localparam int FLG_IO     = 2;

  localparam logic [BANK_W-1:0] SHADOW_OFS = 8'hE0;

  localparam int RAM_BANKS_SMALL = 4;
  localparam int RAM_BANKS_MID   = 20;
  localparam int RAM_BANKS_LARGE = 132;

  typedef struct packed {
    logic [BANK_W-1:0] dest;
    logic [7:0]        flags;
  } map_ent_t;

  typedef struct packed {
    logic              rd_en;
    logic              wr_en;
    logic              rd_rom;
    logic [BANK_W-1:0] rd_base;
    logic [BANK_W-1:0] wr_base;
  } bank_desc_t;

  typedef enum logic [1:0] {SRC_NONE, SRC_RAM, SRC_ROM} rd_src_e;

  function automatic logic [BANK_W:0] bank_limit(input logic [1:0] model);
    case (model)
      2'd0:    return (BANK_W+1)'(RAM_BANKS_SMALL);
      2'd1:    return (BANK_W+1)'(RAM_BANKS_MID);
      default: return (BANK_W+1)'(RAM_BANKS_LARGE);
    endcase
  endfunction
endpackage

// File: rtl/bm_page_map.sv
module bm_page_map
  import bm_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  map_ent_t         wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output map_ent_t         rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  map_ent_t tbl [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (we_i) begin
      tbl[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = tbl[ridx_i];
endmodule

// File: rtl/bm_bank_desc.sv
module bm_bank_desc
  import bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] widx_i,
  input  bank_desc_t        wdata_i,
  input  logic [BANK_W-1:0] ridx_a_i,
  output bank_desc_t        rdata_a_o,
  input  logic [BANK_W-1:0] ridx_b_i,
  output logic              wr_en_b_o,
  output logic [BANK_W-1:0] wr_base_b_o
);
  localparam int DEPTH = 1 << BANK_W;

  bank_desc_t tbl [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (we_i) begin
      tbl[widx_i] <= wdata_i;
    end
  end

  assign rdata_a_o   = tbl[ridx_a_i];
  assign wr_en_b_o   = tbl[ridx_b_i].wr_en;
  assign wr_base_b_o = tbl[ridx_b_i].wr_base;
endmodule

// File: rtl/bm_wait_timer.sv
module bm_wait_timer #(
  parameter int FAST_COST = 5,
  parameter int SLOW_COST = 14,
  localparam int CNT_W = $clog2(SLOW_COST + 1),
  localparam int FPH_W = $clog2(FAST_COST),
  localparam int SPH_W = $clog2(SLOW_COST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             slow_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ready_o,
  output logic [CNT_W-1:0] cost_o,
  output logic [FPH_W-1:0] fast_ph_o,
  output logic [SPH_W-1:0] slow_ph_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, cost_q, cost_d;
  logic [FPH_W-1:0] fast_q, fast_nx;
  logic [SPH_W-1:0] slow_q, slow_nx;

  assign cost_d  = slow_i ? CNT_W'(SLOW_COST) : CNT_W'(FAST_COST);
  assign fast_nx = FPH_W'((int'(fast_q) + int'(cost_q)) % FAST_COST);
  assign slow_nx = SPH_W'((int'(slow_q) + int'(cost_q)) % SLOW_COST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cost_q <= '0;
      fast_q <= '0;
      slow_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
      cost_q <= cost_d;
    end else if (busy_q) begin
      if (cnt_q == cost_q) begin
        busy_q <= 1'b0;
        fast_q <= fast_nx;
        slow_q <= slow_nx;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign cnt_o     = cnt_q;
  assign ready_o   = busy_q && (cnt_q == cost_q);
  assign cost_o    = cost_q;
  assign fast_ph_o = fast_q;
  assign slow_ph_o = slow_q;

  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R9
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R9
  AST_COST_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cost_o == CNT_W'(FAST_COST) || cost_o == CNT_W'(SLOW_COST))); // R8
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ($stable(fast_ph_o) && $stable(slow_ph_o))); // R10
endmodule

// File: rtl/bus_mapper.sv
module bus_mapper
  import bm_pkg::*;
#(
  parameter int MAP_IDX_W = 10,
  parameter int FAST_COST = 5,
  parameter int SLOW_COST = 14
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [1:0]                           mem_model_i,
  input  logic                                 cpu_req_i,
  input  logic                                 cpu_we_i,
  input  logic [23:0]                          cpu_addr_i,
  input  logic [7:0]                           cpu_wdata_i,
  output logic [7:0]                           cpu_rdata_o,
  output logic                                 cpu_ready_o,
  output logic [$clog2(SLOW_COST+1)-1:0]       cost_o,
  output logic [$clog2(FAST_COST)-1:0]         fast_phase_o,
  output logic [$clog2(SLOW_COST)-1:0]         slow_phase_o,
  input  logic                                 map_we_i,
  input  logic [MAP_IDX_W-1:0]                 map_idx_i,
  input  logic [15:0]                          map_wdata_i,
  input  logic                                 desc_we_i,
  input  logic [7:0]                           desc_idx_i,
  input  logic [18:0]                          desc_wdata_i,
  output logic                                 ram_re_o,
  output logic                                 ram_we_o,
  output logic [23:0]                          ram_addr_o,
  output logic [7:0]                           ram_wdata_o,
  input  logic [7:0]                           ram_rdata_i,
  output logic                                 rom_re_o,
  output logic [23:0]                          rom_addr_o,
  input  logic [7:0]                           rom_rdata_i,
  output logic                                 io_req_o,
  output logic                                 io_we_o,
  output logic [23:0]                          io_addr_o,
  output logic [7:0]                           io_wdata_o,
  input  logic [7:0]                           io_rdata_i
);
  localparam int CNT_W = $clog2(SLOW_COST + 1);

  map_ent_t          map_rd;
  bank_desc_t        dsc_rd;
  logic              shd_en_rd;
  logic [BANK_W-1:0] shd_base_rd;
  logic              busy, ready;
  logic [CNT_W-1:0]  cnt;
  logic              accept, slow_acc, step1, step2;
  logic [BANK_W:0]   limit;

  logic [ADDR_W-1:0] a_addr;
  logic              a_we, a_io, a_shadow;
  logic [7:0]        a_wd;
  bank_desc_t        a_dp;
  logic              a_ds_en;
  logic [BANK_W-1:0] a_ds_base;
  rd_src_e           pend;
  logic [7:0]        rdata_q;
  logic              prim_wr_ok, shd_wr_ok, rd_ram_ok;
  logic              unused_flags;

  bm_page_map #(.IDX_W(MAP_IDX_W)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (map_we_i),
    .widx_i  (map_idx_i),
    .wdata_i (map_ent_t'(map_wdata_i)),
    .ridx_i  (cpu_addr_i[8 +: MAP_IDX_W]),
    .rdata_o (map_rd)
  );

  bm_bank_desc u_desc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (desc_we_i),
    .widx_i      (desc_idx_i),
    .wdata_i     (bank_desc_t'(desc_wdata_i)),
    .ridx_a_i    (map_rd.dest),
    .rdata_a_o   (dsc_rd),
    .ridx_b_i    (BANK_W'(map_rd.dest + SHADOW_OFS)),
    .wr_en_b_o   (shd_en_rd),
    .wr_base_b_o (shd_base_rd)
  );

  assign accept   = cpu_req_i && !busy;
  assign slow_acc = map_rd.flags[FLG_SLOW] || (cpu_we_i && map_rd.flags[FLG_SHADOW]);
  assign unused_flags = ^map_rd.flags[7:3];

  bm_wait_timer #(.FAST_COST(FAST_COST), .SLOW_COST(SLOW_COST)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .slow_i    (slow_acc),
    .busy_o    (busy),
    .cnt_o     (cnt),
    .ready_o   (ready),
    .cost_o    (cost_o),
    .fast_ph_o (fast_phase_o),
    .slow_ph_o (slow_phase_o)
  );

  assign step1 = busy && (cnt == CNT_W'(1));
  assign step2 = busy && (cnt == CNT_W'(2));
  assign limit = bank_limit(mem_model_i);

  assign prim_wr_ok = a_dp.wr_en && ({1'b0, a_dp.wr_base} < limit);
  assign shd_wr_ok  = a_shadow && prim_wr_ok && a_ds_en && ({1'b0, a_ds_base} < limit);
  assign rd_ram_ok  = a_dp.rd_en && !a_dp.rd_rom && ({1'b0, a_dp.rd_base} < limit);

  // primary access on count 1, shadow copy on count 2
  assign io_req_o    = step1 && a_io;
  assign io_we_o     = a_we;
  assign io_addr_o   = a_addr;
  assign io_wdata_o  = a_wd;
  assign ram_we_o    = !a_io && a_we && ((step1 && prim_wr_ok) || (step2 && shd_wr_ok));
  assign ram_re_o    = step1 && !a_io && !a_we && rd_ram_ok;
  assign rom_re_o    = step1 && !a_io && !a_we && a_dp.rd_en && a_dp.rd_rom;
  assign ram_addr_o  = {step2 ? a_ds_base : (a_we ? a_dp.wr_base : a_dp.rd_base), a_addr[OFS_W-1:0]};
  assign ram_wdata_o = a_wd;
  assign rom_addr_o  = {a_dp.rd_base, a_addr[OFS_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_addr    <= '0;
      a_we      <= 1'b0;
      a_io      <= 1'b0;
      a_shadow  <= 1'b0;
      a_wd      <= '0;
      a_dp      <= '0;
      a_ds_en   <= 1'b0;
      a_ds_base <= '0;
      pend      <= SRC_NONE;
      rdata_q   <= 8'hFF;
    end else begin
      if (accept) begin
        a_addr    <= cpu_addr_i;
        a_we      <= cpu_we_i;
        a_io      <= map_rd.flags[FLG_IO];
        a_shadow  <= map_rd.flags[FLG_SHADOW];
        a_wd      <= cpu_wdata_i;
        a_dp      <= dsc_rd;
        a_ds_en   <= shd_en_rd;
        a_ds_base <= shd_base_rd;
        pend      <= SRC_NONE;
        rdata_q   <= 8'hFF;
      end
      if (step1) begin
        if (a_io && !a_we) rdata_q <= io_rdata_i;
        pend <= ram_re_o ? SRC_RAM : (rom_re_o ? SRC_ROM : SRC_NONE);
      end
      if (step2) begin
        case (pend)
          SRC_RAM: rdata_q <= ram_rdata_i;
          SRC_ROM: rdata_q <= rom_rdata_i;
          default: ;
        endcase
        pend <= SRC_NONE;
      end
    end
  end

  assign cpu_rdata_o = rdata_q;
  assign cpu_ready_o = ready;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_we_o, ram_re_o, rom_re_o, io_req_o})); // R3
  AST_IO_NO_STORAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && a_io) |-> !(ram_we_o || ram_re_o || rom_re_o)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !(ram_we_o || ram_re_o || rom_re_o || io_req_o)); // R9
  AST_READ_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !a_we) |-> !ram_we_o); // R5
  AST_SHADOW_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && step2) |-> $past(ram_we_o)); // R7
endmodule

// File: tb/sim_bus_mapper.sv
`timescale 1ns/1ps
module sim_bus_mapper;
  localparam int MI = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    mem_model_i = 2'd2;
  logic          cpu_req_i = 0, cpu_we_i = 0;
  logic [23:0]   cpu_addr_i = '0;
  logic [7:0]    cpu_wdata_i = '0;
  logic [7:0]    cpu_rdata_o;
  logic          cpu_ready_o;
  logic [3:0]    cost_o;
  logic [2:0]    fast_phase_o;
  logic [3:0]    slow_phase_o;
  logic          map_we_i = 0;
  logic [MI-1:0] map_idx_i = '0;
  logic [15:0]   map_wdata_i = '0;
  logic          desc_we_i = 0;
  logic [7:0]    desc_idx_i = '0;
  logic [18:0]   desc_wdata_i = '0;
  logic          ram_re_o, ram_we_o, rom_re_o, io_req_o, io_we_o;
  logic [23:0]   ram_addr_o, rom_addr_o, io_addr_o;
  logic [7:0]    ram_wdata_o, io_wdata_o;
  logic [7:0]    ram_rdata_i = '0, rom_rdata_i = '0;
  logic [7:0]    io_rdata_i;

  bus_mapper #(.MAP_IDX_W(MI)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mem_model_i(mem_model_i),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .cpu_ready_o(cpu_ready_o),
    .cost_o(cost_o), .fast_phase_o(fast_phase_o), .slow_phase_o(slow_phase_o),
    .map_we_i(map_we_i), .map_idx_i(map_idx_i), .map_wdata_i(map_wdata_i),
    .desc_we_i(desc_we_i), .desc_idx_i(desc_idx_i), .desc_wdata_i(desc_wdata_i),
    .ram_re_o(ram_re_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .rom_re_o(rom_re_o), .rom_addr_o(rom_addr_o), .rom_rdata_i(rom_rdata_i),
    .io_req_o(io_req_o), .io_we_o(io_we_o), .io_addr_o(io_addr_o),
    .io_wdata_o(io_wdata_o), .io_rdata_i(io_rdata_i)
  );

  int n_tests = 0;
  int n_fail = 0;
  int ef = 0, es = 0;
  logic [7:0]  ram_m [int];
  logic [15:0] bmap [1024];
  logic [18:0] bdesc [256];
  logic [23:0] wlog [4];
  int wn = 0, rn = 0, io_n = 0;

  function automatic logic [7:0] rom_fn(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hC3;
  endfunction

  function automatic logic [7:0] ram_val(input logic [23:0] a);
    if (ram_m.exists(int'(a))) return ram_m[int'(a)];
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic int lim(input logic [1:0] m);
    case (m)
      2'd0: return 4;
      2'd1: return 20;
      default: return 132;
    endcase
  endfunction

  assign io_rdata_i = io_addr_o[7:0] ^ 8'h3C;

  always @(posedge clk) begin
    if (ram_we_o) begin
      if (wn < 4) wlog[wn] = ram_addr_o;
      wn++;
      ram_m[int'(ram_addr_o)] = ram_wdata_o;
    end
    if (ram_re_o) begin
      ram_rdata_i <= ram_val(ram_addr_o);
      rn++;
    end
    if (rom_re_o) begin
      rom_rdata_i <= rom_fn(rom_addr_o);
      rn++;
    end
    if (io_req_o) io_n++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic map_write(input logic [MI-1:0] idx, input logic [15:0] val);
    @(negedge clk);
    map_we_i = 1; map_idx_i = idx; map_wdata_i = val;
    @(negedge clk);
    map_we_i = 0;
    bmap[idx] = val;
  endtask

  task automatic desc_write(input logic [7:0] idx, input logic [18:0] val);
    @(negedge clk);
    desc_we_i = 1; desc_idx_i = idx; desc_wdata_i = val;
    @(negedge clk);
    desc_we_i = 0;
    bdesc[idx] = val;
  endtask

  // descriptor: {rd_en, wr_en, rd_rom, rd_base, wr_base}
  function automatic logic [18:0] dsc(input bit r, input bit w, input bit rom, input logic [7:0] rb, input logic [7:0] wb);
    return {r, w, rom, rb, wb};
  endfunction

  task automatic access(input string tag, input logic we, input logic [23:0] a, input logic [7:0] wd,
                        input bit cfg = 0, input logic [MI-1:0] cidx = '0, input logic [15:0] cval = '0);
    logic [15:0] ent;
    logic [18:0] dp, ds;
    int lv, cost, e_nw, e_rds, e_io, n;
    logic [23:0] e_w0, e_w1;
    logic [7:0] e_rd;
    ent = bmap[a[8 +: MI]];
    dp = bdesc[ent[15:8]];
    ds = bdesc[8'(ent[15:8] + 8'hE0)];
    lv = lim(mem_model_i);
    cost = (ent[1] || (we && ent[0])) ? 14 : 5;
    e_nw = 0; e_rds = 0; e_io = 0; e_rd = 8'hFF; e_w0 = '0; e_w1 = '0;
    if (ent[2]) begin
      e_io = 1;
      if (!we) e_rd = a[7:0] ^ 8'h3C;
    end else if (we) begin
      if (dp[17] && int'(dp[7:0]) < lv) begin
        e_nw = 1; e_w0 = {dp[7:0], a[15:0]};
        if (ent[0] && ds[17] && int'(ds[7:0]) < lv) begin
          e_nw = 2; e_w1 = {ds[7:0], a[15:0]};
        end
      end
    end else if (dp[18]) begin
      if (dp[16]) begin
        e_rds = 1; e_rd = rom_fn({dp[15:8], a[15:0]});
      end else if (int'(dp[15:8]) < lv) begin
        e_rds = 1; e_rd = ram_val({dp[15:8], a[15:0]});
      end
    end
    @(negedge clk);
    wn = 0; rn = 0; io_n = 0;
    cpu_req_i = 1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = wd;
    if (cfg) begin
      map_we_i = 1; map_idx_i = cidx; map_wdata_i = cval;
    end
    @(negedge clk);
    cpu_req_i = 0; map_we_i = 0;
    if (cfg) bmap[cidx] = cval;
    n = 1;
    while (!cpu_ready_o && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R9", n, cost, "ready cycle");
    chk("R8", 32'(cost_o), cost, "cost");
    if (!we) chk(tag, 32'(cpu_rdata_o), 32'(e_rd), "read data");
    @(negedge clk);
    chk("R9", 32'(cpu_ready_o), 0, "ready width");
    ef = (ef + cost) % 5;
    es = (es + cost) % 14;
    chk("R10", 32'(fast_phase_o), ef, "fast phase");
    chk("R10", 32'(slow_phase_o), es, "slow phase");
    chk(tag, wn, e_nw, "ram writes");
    if (e_nw > 0) chk(tag, 32'(wlog[0]), 32'(e_w0), "write addr");
    if (e_nw > 1) chk(tag, 32'(wlog[1]), 32'(e_w1), "shadow addr");
    chk(tag, rn, e_rds, "read strobes");
    chk(tag, io_n, e_io, "io strobes");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [MI-1:0] pg [16];
    void'($urandom(32'd61021));
    for (int i = 0; i < 1024; i++) bmap[i] = '0;
    for (int i = 0; i < 256; i++) bdesc[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2", 32'(cpu_ready_o), 0, "ready at reset");
    chk("R2", 32'(cost_o), 0, "cost at reset");
    chk("R2", 32'(fast_phase_o), 0, "fast at reset");
    chk("R2", 32'(slow_phase_o), 0, "slow at reset");
    access("R2", 0, 24'h123456, 8'h00);
    access("R2", 1, 24'hABCDEF, 8'h11);

    // R1 R3 R5 plain RAM bank
    desc_write(8'd1, dsc(1, 1, 0, 8'd2, 8'd2));
    map_write(10'h012, 16'h0100);
    access("R5", 1, 24'h001234, 8'hAB);
    access("R1", 0, 24'h001234, 8'h00);
    access("R3", 0, 24'h0012F0, 8'h00);

    // R3 read from ROM, write to RAM
    desc_write(8'd3, dsc(1, 1, 1, 8'd5, 8'd6));
    map_write(10'h020, 16'h0300);
    access("R3", 0, 24'h002055, 8'h00);
    access("R5", 1, 24'h002055, 8'h77);
    access("R3", 0, 24'h002055, 8'h00);

    // R5 write protected, R4 no read enable
    desc_write(8'd4, dsc(1, 0, 0, 8'd1, 8'd1));
    map_write(10'h030, 16'h0400);
    access("R5", 1, 24'h003010, 8'h99);
    access("R3", 0, 24'h003010, 8'h00);
    desc_write(8'd5, dsc(0, 1, 0, 8'd2, 8'd2));
    map_write(10'h031, 16'h0500);
    access("R4", 0, 24'h003120, 8'h00);

    // R6 IO pages, R8 IO with slow flag
    map_write(10'h040, 16'h0104);
    access("R6", 0, 24'h004077, 8'h00);
    access("R6", 1, 24'h004078, 8'h5D);
    map_write(10'h041, 16'h0107);
    access("R8", 1, 24'h004100, 8'h12);

    // R8 slow page
    map_write(10'h050, 16'h0102);
    access("R8", 0, 24'h005003, 8'h00);
    access("R8", 1, 24'h005004, 8'h44);

    // R7 shadow
    desc_write(8'hE1, dsc(0, 1, 0, 8'd0, 8'd3));
    map_write(10'h060, 16'h0101);
    access("R7", 1, 24'h006042, 8'hC1);
    access("R7", 0, 24'h006042, 8'h00);
    desc_write(8'hE1, dsc(0, 0, 0, 8'd0, 8'd3));
    access("R7", 1, 24'h006043, 8'hC2);
    desc_write(8'h30, dsc(1, 1, 0, 8'd7, 8'd7));
    desc_write(8'h10, dsc(0, 1, 0, 8'd0, 8'd8));
    map_write(10'h070, 16'h3001);
    access("R7", 1, 24'h0070AA, 8'hC3);
    map_write(10'h071, 16'h0405);
    access("R7", 1, 24'h007101, 8'hC4);

    // R11 installed size
    desc_write(8'd9, dsc(1, 1, 0, 8'd10, 8'd10));
    map_write(10'h080, 16'h0900);
    mem_model_i = 2'd0;
    access("R11", 1, 24'h008011, 8'h3E);
    access("R11", 0, 24'h008011, 8'h00);
    mem_model_i = 2'd1;
    access("R11", 1, 24'h008011, 8'h3F);
    access("R11", 0, 24'h008011, 8'h00);
    mem_model_i = 2'd2;
    desc_write(8'd9, dsc(1, 1, 0, 8'd131, 8'd132));
    access("R11", 1, 24'h008012, 8'h40);
    access("R11", 0, 24'h008012, 8'h00);
    mem_model_i = 2'd3;
    access("R4", 0, 24'h008013, 8'h00);

    // R12 map write on the accepting edge
    access("R12", 0, 24'h009033, 8'h00, 1, 10'h090, 16'h0100);
    access("R12", 0, 24'h009033, 8'h00);
    access("R12", 1, 24'h009034, 8'h21, 1, 10'h090, 16'h0102);
    access("R12", 1, 24'h009034, 8'h22);

    // R1 random descriptors, pages and traffic
    for (int i = 0; i < 256; i++)
      desc_write(8'(i), dsc(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 3) == 0,
                            8'($urandom_range(0, 150)), 8'($urandom_range(0, 150))));
    for (int k = 0; k < 16; k++) begin
      pg[k] = MI'($urandom);
      map_write(pg[k], {8'($urandom), 5'($urandom), 3'($urandom)});
    end
    for (int i = 0; i < 300; i++) begin
      logic [23:0] ra;
      ra = {6'($urandom), pg[$urandom % 16], 8'($urandom)};
      if (($urandom % 16) == 0) begin
        @(negedge clk);
        mem_model_i = 2'($urandom);
      end
      if (($urandom % 10) == 0)
        access("R12", 1'($urandom), ra, 8'($urandom), 1, ra[8 +: MI],
               {8'($urandom), 5'd0, 3'($urandom)});
      else
        access("R1", 1'($urandom), ra, 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule